// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is an eight-pin general purpose I/O port hanging off a processor's dedicated I/O bus. The processor reaches it with simple IN and OUT style cycles: an address, a write strobe with write data, and a read strobe that returns read data in the same cycle. Inside sit an output value latch, a per-pin drive-enable (direction) register and a synchronized sample of the external pin levels.

Each pin is presented as a tri-state pair: a drive-enable bit and a drive-value bit, plus a raw input bit from the pad. The direction and output registers each have a fixed address in a three-register window and can be reached on any cycle, so firmware can float or drive a single pin with one write. Leaving the output bit at 0 and toggling only the direction bit gives an open-drain line suitable for bit-banged two-wire buses, with an external pullup raising the released line.

Top module: `gpio_port`

## Requirements
- R1: The output value latch keeps its contents, and `pin_out` keeps driving them, on every cycle that carries no write to offset 0.
- R2: `pin_oe[i]` is 1 exactly when direction bit i is 1; `pin_out` always presents the output latch, whatever the direction bits hold.
- R3: A read of offset 2 returns the external level on `pin_in`, not the output latch, even for pins that are being driven.
- R4: `pin_in` passes through a two-flop synchronizer: a level applied before clock edge k is not visible to an offset-2 read before edge k+1 and is visible from the cycle after edge k+1.
- R5: Register window relative to `BASE`: offset 0 is the output latch (read/write, reads back the latch), offset 1 the direction register (read/write), offset 2 the pin level (read-only). Both writable registers are reachable on any access with no prior select write.
- R6: A write to offset 2 changes neither the output latch nor the direction register.
- R7: Synchronous active-high reset clears the direction register and the output latch to zero, so no pin is driven.
- R8: `io_rdata` carries the addressed register in the cycle `io_rd` is high with an in-window address, and is zero at every other time, including offset 3 and addresses outside the window.
- R9: A write to an address outside `BASE` .. `BASE`+2 changes no state.
- R10: With the output bit at 0, a single direction write pulls the pin low (`pin_oe`=1, `pin_out`=0) and a single further write releases it (`pin_oe`=0), leaving the output latch at 0.
- R11: Write data is captured on the rising clock edge at which `io_wr` and a matching address are both high; the outputs do not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | I/O bus address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | WIDTH | Write data |
| io_rdata | output | WIDTH | Read data, zero when not selected |
| pin_in | input | WIDTH | Raw pad input levels |
| pin_oe | output | WIDTH | Per-pin drive enable |
| pin_out | output | WIDTH | Per-pin drive value |

## Verification
The hardest case to reach from the ports is the synchronizer window: the bench must change `pin_in` and read offset 2 exactly one edge later, then again one edge after that, to show the old value still present and then the new one. It holds the read strobe across those two consecutive cycles with the pin change placed on the falling edge before them. A second hard case is proving that a pin-level read ignores the latch, which the bench reaches by driving an output pattern that differs bit-for-bit from the external levels while all pins are enabled.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PINS = 2'd2,
    SEL_NONE = 2'd3
  } port_sel_e;

  localparam int NUM_REGS = 3;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h40
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output port_sel_e         sel,
  output logic              wr_data,
  output logic              wr_dir,
  output logic              rd_hit
);
  logic [ADDR_W-1:0] offset;
  logic              in_window;

  always_comb begin
    offset    = addr - BASE;
    in_window = (addr >= BASE) && (offset < ADDR_W'(NUM_REGS));
    sel       = in_window ? port_sel_e'(offset[1:0]) : SEL_NONE;
    wr_data   = wr && (sel == SEL_DATA);
    wr_dir    = wr && (sel == SEL_DIR);
    rd_hit    = rd && (sel != SEL_NONE);
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

  // R4: the last stage only ever takes the value the previous stage held
  assert_sync_shift_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> chain[STAGES-1] == $past(chain[STAGES-2]));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_data,
  input  logic             wr_dir,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_data) data_q <= wdata;
      if (wr_dir)  dir_q  <= wdata;
    end
  end

  assert_latch_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !wr_data |=> $stable(data_q));

  assert_write_capture_R11: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> dir_q == $past(wdata));

  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (data_q == '0) && (dir_q == '0));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [WIDTH-1:0]  io_wdata,
  output logic [WIDTH-1:0]  io_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_oe,
  output logic [WIDTH-1:0]  pin_out
);
  localparam int SYNC_STAGES = 2;

  port_sel_e        sel;
  logic             wr_data, wr_dir, rd_hit;
  logic [WIDTH-1:0] data_q, dir_q, pins_sync;

  gpio_addr_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr(io_addr), .wr(io_wr), .rd(io_rd),
    .sel(sel), .wr_data(wr_data), .wr_dir(wr_dir), .rd_hit(rd_hit)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .wr_data(wr_data), .wr_dir(wr_dir),
    .wdata(io_wdata), .data_q(data_q), .dir_q(dir_q)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pins_sync)
  );

  always_comb begin
    io_rdata = '0;
    if (rd_hit) begin
      unique case (sel)
        SEL_DATA: io_rdata = data_q;
        SEL_DIR:  io_rdata = dir_q;
        SEL_PINS: io_rdata = pins_sync;
        default:  io_rdata = '0;
      endcase
    end
  end

  assign pin_out = data_q;
  assign pin_oe  = dir_q;

  // cycles since reset, saturating, for the latency check
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= '0;
    else if (since_rst != 2) since_rst <= since_rst + 2'd1;
  end

  assert_pin_latency_R4: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd2) |-> pins_sync == $past(pin_in, 2));

  assert_rdata_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !io_rd |-> io_rdata == '0);

  assert_pins_readonly_R6: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == BASE + ADDR_W'(2)) |=> $stable(pin_out) && $stable(pin_oe));

  assert_outside_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (io_wr && (io_addr < BASE || io_addr > BASE + ADDR_W'(2))) |=>
      $stable(pin_out) && $stable(pin_oe));

  assert_no_drive_after_reset_R7: assert property (@(posedge clk)
    rst |=> pin_oe == '0);
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  localparam int W = 8;
  localparam logic [7:0] BASE = 8'h40;

  // kinds: 0 write, 1 read-and-compare, 2 set pins (then two edges), 3 pad compare
  typedef struct packed {
    logic [1:0] kind;
    logic [7:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] tag;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{2'd1, BASE,        8'h00, 8'h00, 4'd7},  // R7 latch cleared
    '{2'd1, BASE+8'd1,   8'h00, 8'h00, 4'd7},  // R7 direction cleared
    '{2'd3, 8'h00,       8'h00, 8'h00, 4'd7},  // R7 nothing driven
    '{2'd0, BASE,        8'hA5, 8'h00, 4'd5},
    '{2'd1, BASE,        8'h00, 8'hA5, 4'd5},  // R5 latch readback
    '{2'd3, 8'h00,       8'hA5, 8'h00, 4'd2},  // R2 value out, not enabled
    '{2'd0, BASE+8'd1,   8'h0F, 8'h00, 4'd5},
    '{2'd3, 8'h00,       8'hA5, 8'h0F, 4'd2},  // R2 low nibble enabled
    '{2'd1, BASE+8'd1,   8'h00, 8'h0F, 4'd5},  // R5 direction readback
    '{2'd2, 8'h00,       8'h3C, 8'h00, 4'd3},
    '{2'd1, BASE+8'd2,   8'h00, 8'h3C, 4'd3},  // R3 pin level, not A5
    '{2'd0, BASE+8'd2,   8'hFF, 8'h00, 4'd6},
    '{2'd1, BASE,        8'h00, 8'hA5, 4'd6},  // R6 latch untouched
    '{2'd1, BASE+8'd1,   8'h00, 8'h0F, 4'd6},  // R6 direction untouched
    '{2'd0, BASE+8'd3,   8'h55, 8'h00, 4'd9},
    '{2'd0, 8'h3F,       8'h55, 8'h00, 4'd9},
    '{2'd1, BASE,        8'h00, 8'hA5, 4'd9},  // R9 latch untouched
    '{2'd3, 8'h00,       8'hA5, 8'h0F, 4'd1},  // R1 still driven after idle
    '{2'd1, BASE+8'd3,   8'h00, 8'h00, 4'd8},  // R8 hole reads zero
    '{2'd1, BASE+8'd16,  8'h00, 8'h00, 4'd8},  // R8 foreign address
    '{2'd1, 8'h3F,       8'h00, 8'h00, 4'd8}   // R8 just below window
  };

  logic clk = 0, rst = 1;
  logic [7:0] io_addr = '0, io_wdata = '0, pin_in = '0;
  logic io_wr = 0, io_rd = 0;
  logic [W-1:0] io_rdata, pin_oe, pin_out;
  int checks = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_port #(.WIDTH(W), .ADDR_W(8), .BASE(BASE)) u0 (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out)
  );

  task automatic check(input int tag, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1;
    #1 d = io_rdata;
    io_rd = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    checks++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      case (TBL[i].kind)
        2'd0: bus_write(TBL[i].addr, TBL[i].data);
        2'd1: begin
          bus_read(TBL[i].addr, rv);
          check(int'(TBL[i].tag), "table read", rv, TBL[i].exp);
        end
        2'd2: begin
          @(negedge clk); pin_in = TBL[i].data;
          @(posedge clk); @(posedge clk);
        end
        default: begin
          @(negedge clk);
          check(int'(TBL[i].tag), "table pin_out", pin_out, TBL[i].data);
          check(int'(TBL[i].tag), "table pin_oe", pin_oe, TBL[i].exp);
        end
      endcase
    end

    // R3: all pins driving, read still returns the outside levels
    bus_write(BASE + 8'd1, 8'hFF);
    bus_write(BASE, 8'hF0);
    @(negedge clk); pin_in = 8'h0F;
    @(posedge clk); @(posedge clk);
    bus_read(BASE + 8'd2, rv);
    check(3, "pin read with all enabled", rv, 8'h0F);

    // R4: latency window
    @(negedge clk); pin_in = 8'h81;
    @(negedge clk); io_addr = BASE + 8'd2; io_rd = 1;
    #1 check(4, "one edge after change", io_rdata, 8'h0F);
    @(negedge clk);
    #1 check(4, "two edges after change", io_rdata, 8'h81);
    io_rd = 0;

    // R8: strobe low with in-window address gives zero
    @(negedge clk); io_addr = BASE; io_rd = 0;
    #1 check(8, "rdata with read strobe low", io_rdata, 8'h00);

    // R11: no change before the capturing edge
    @(negedge clk); io_addr = BASE; io_wdata = 8'h77; io_wr = 1;
    #1 check(11, "pin_out before edge", pin_out, 8'hF0);
    @(negedge clk); io_wr = 0;
    check(11, "pin_out after edge", pin_out, 8'h77);

    // R10: open-drain emulation on pin 3
    bus_write(BASE, 8'h00);
    bus_write(BASE + 8'd1, 8'h08);
    check(10, "pull low oe", pin_oe, 8'h08);
    check(10, "pull low value", pin_out, 8'h00);
    bus_write(BASE + 8'd1, 8'h00);
    check(10, "release oe", pin_oe, 8'h00);
    bus_read(BASE, rv);
    check(10, "latch stays zero", rv, 8'h00);

    // R7: reset in mid-run
    bus_write(BASE, 8'hC3);
    bus_write(BASE + 8'd1, 8'h3C);
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    check(7, "pin_oe after reset", pin_oe, 8'h00);
    check(7, "pin_out after reset", pin_out, 8'h00);
    bus_read(BASE + 8'd1, rv);
    check(7, "direction after reset", rv, 8'h00);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule